// File: doc/BRIEF.md
# Interlocked Handshake Bus Master

This block is the master side of an unclocked-style parallel bus on which every transfer is paced by two control lines: a master strobe (`bus_mrdy`) and a slave answer (`bus_srdy`). A local client hands it one read or write at a time. The master places the address and direction on the bus, and for a write also the data. It holds them for a programmable skew guard before it raises its strobe. It then waits for the slave to answer. Once the answer has arrived it keeps everything in place for a second guard interval, then withdraws the strobe and the bus, and waits for the slave to withdraw its answer.

The slave answer arrives with no relation to the local clock, so it passes through a two-stage synchronizer before the controller acts on it. Read data are sampled on the cycle the synchronized answer is first seen. Those data were placed on the bus before the answer was raised, so they have had at least two clock periods to settle. If no answer arrives within a programmable number of clocks, the master abandons the transfer and reports an error.

The controller has five states. `ST_IDLE` waits for a request and moves to `ST_SETUP` when one is accepted. `ST_SETUP` drives the address and moves to `ST_WAIT` when the front guard expires. `ST_WAIT` holds the strobe high. It moves to `ST_HOLD` when the answer is seen, or to `ST_RELEASE` on timeout. `ST_HOLD` moves to `ST_RELEASE` when the rear guard expires. `ST_RELEASE` moves to `ST_IDLE` once the answer is low again, and it issues the response on that transition.

Top module: `hsk_bus_master`

## Requirements
- R1: After reset, `bus_mrdy`, `bus_drive` and `resp_valid` are 0 and `req_ready` is 1.
- R2: `bus_drive` is high with valid address, command and write data for exactly SKEW_PRE clock periods before `bus_mrdy` rises, and `bus_mrdy` is never high without `bus_drive`.
- R3: On a write (`req_write`=1), the slave sees the requested address and data on the bus when `bus_mrdy` rises. The response carries `resp_err`=0.
- R4: On a read (`req_write`=0), the data the slave presents with `bus_srdy` are returned on `resp_rdata` with `resp_err`=0.
- R5: After `bus_srdy` rises, `bus_mrdy` and the bus stay driven for SKEW_POST+2 further sampled clock periods: two for synchronization, then SKEW_POST of guard.
- R6: The response is a single-cycle `resp_valid` pulse issued only after `bus_mrdy` has fallen and `bus_srdy` has returned to 0.
- R7: `req_ready` is 0 from acceptance until `bus_srdy` is back at 0 after the cycle. A `req_valid` presented while `req_ready` is 0 is ignored and produces no bus cycle and no response.
- R8: If `bus_srdy` does not arrive within TMO_CYC clocks of `bus_mrdy` rising, `bus_mrdy` falls after exactly TMO_CYC periods, the bus is released, and the response carries `resp_err`=1.
- R9: Address, command and write data stay stable for as long as `bus_drive` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Local request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Request address |
| req_wdata | input | DW | Write data |
| req_ready | output | 1 | Request accepted on this edge when high together with req_valid |
| resp_valid | output | 1 | One-cycle completion pulse |
| resp_err | output | 1 | Completion was a timeout |
| resp_rdata | output | DW | Read data of the last read |
| bus_addr | output | AW | Bus address (0 when released) |
| bus_write | output | 1 | Bus command, 1 = write |
| bus_wdata | output | DW | Bus write data |
| bus_drive | output | 1 | Address, command and data are being driven |
| bus_mrdy | output | 1 | Master ready strobe |
| bus_srdy | input | 1 | Slave ready answer, asynchronous |
| bus_rdata | input | DW | Read data from the slave |

## Verification
Once a request is accepted, the strobe is due SKEW_PRE periods later. After the answer rises, the strobe drops on the (SKEW_POST+3)-th rising edge, and the response follows three edges after the answer falls. A timed-out strobe drops after TMO_CYC periods. A bench slave raises and lowers its answer 1 ns after a falling edge. The monitor samples every falling edge and counts the periods spent in each phase. It compares each count with the parameter-derived figure when the strobe changes, so every check lands on the edge where the result is due. Completions are matched against a queue of expected results, which the driver fills from its own memory model, in issue order.

// File: rtl/hsk_pkg.sv
package hsk_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_WAIT,
        ST_HOLD,
        ST_RELEASE
    } hsk_state_e;
endpackage

// File: rtl/hsk_sync2.sv
module hsk_sync2 (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic sync_out
);
    logic stage1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage1   <= 1'b0;
            sync_out <= 1'b0;
        end else begin
            stage1   <= async_in;
            sync_out <= stage1;
        end
    end
endmodule

// File: rtl/hsk_phase_timer.sv
module hsk_phase_timer #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          restart,
    output logic [CW-1:0] elapsed
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            elapsed <= '0;
        end else if (restart) begin
            elapsed <= '0;
        end else if (elapsed != {CW{1'b1}}) begin
            elapsed <= elapsed + 1'b1;
        end
    end
endmodule

// File: rtl/hsk_bus_master.sv
module hsk_bus_master
    import hsk_pkg::*;
#(
    parameter int AW        = 16,
    parameter int DW        = 16,
    parameter int SKEW_PRE  = 2,
    parameter int SKEW_POST = 2,
    parameter int TMO_CYC   = 64
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic          req_write,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    output logic          req_ready,
    output logic          resp_valid,
    output logic          resp_err,
    output logic [DW-1:0] resp_rdata,
    output logic [AW-1:0] bus_addr,
    output logic          bus_write,
    output logic [DW-1:0] bus_wdata,
    output logic          bus_drive,
    output logic          bus_mrdy,
    input  logic          bus_srdy,
    input  logic [DW-1:0] bus_rdata
);
    localparam int PRE_C   = (SKEW_PRE  < 1) ? 1 : SKEW_PRE;
    localparam int POST_C  = (SKEW_POST < 1) ? 1 : SKEW_POST;
    localparam int TMO_C   = (TMO_CYC   < 1) ? 1 : TMO_CYC;
    localparam int MAX_AB  = (PRE_C > POST_C) ? PRE_C : POST_C;
    localparam int MAX_ALL = (MAX_AB > TMO_C) ? MAX_AB : TMO_C;
    localparam int CW      = $clog2(MAX_ALL + 1);
    localparam logic [CW-1:0] PRE_LAST  = CW'(PRE_C - 1);
    localparam logic [CW-1:0] POST_LAST = CW'(POST_C - 1);
    localparam logic [CW-1:0] TMO_LAST  = CW'(TMO_C - 1);

    hsk_state_e    state, state_nxt;
    logic          srdy_s;
    logic [CW-1:0] elapsed;
    logic          accept;
    logic [AW-1:0] addr_q;
    logic          write_q;
    logic [DW-1:0] wdata_q;
    logic [DW-1:0] rdata_q;
    logic          err_q;
    logic          resp_q;

    hsk_sync2 u_srdy_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (bus_srdy),
        .sync_out (srdy_s)
    );

    hsk_phase_timer #(.CW(CW)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (state_nxt != state),
        .elapsed (elapsed)
    );

    assign accept = req_valid && req_ready;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nxt;
        end
    end

    // Transitions
    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_IDLE: begin
                if (accept) state_nxt = ST_SETUP;
            end
            ST_SETUP: begin
                if (elapsed == PRE_LAST) state_nxt = ST_WAIT;
            end
            ST_WAIT: begin
                if (srdy_s)                    state_nxt = ST_HOLD;
                else if (elapsed == TMO_LAST)  state_nxt = ST_RELEASE;
            end
            ST_HOLD: begin
                if (elapsed == POST_LAST) state_nxt = ST_RELEASE;
            end
            ST_RELEASE: begin
                if (!srdy_s) state_nxt = ST_IDLE;
            end
            default: state_nxt = ST_IDLE;
        endcase
    end

    // Request capture, read-data strobe and completion
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q  <= '0;
            write_q <= 1'b0;
            wdata_q <= '0;
            rdata_q <= '0;
            err_q   <= 1'b0;
            resp_q  <= 1'b0;
        end else begin
            resp_q <= (state == ST_RELEASE) && !srdy_s;
            if (accept) begin
                addr_q  <= req_addr;
                write_q <= req_write;
                wdata_q <= req_wdata;
                err_q   <= 1'b0;
            end
            if (state == ST_WAIT) begin
                if (srdy_s && !write_q) begin
                    rdata_q <= bus_rdata;
                end else if (!srdy_s && elapsed == TMO_LAST) begin
                    err_q <= 1'b1;
                end
            end
        end
    end

    // Outputs decoded from state
    always_comb begin
        bus_drive = 1'b0;
        bus_mrdy  = 1'b0;
        req_ready = 1'b0;
        unique case (state)
            ST_IDLE:    req_ready = !srdy_s;
            ST_SETUP:   bus_drive = 1'b1;
            ST_WAIT,
            ST_HOLD: begin
                bus_drive = 1'b1;
                bus_mrdy  = 1'b1;
            end
            ST_RELEASE: ;
            default: ;
        endcase
        bus_addr   = bus_drive ? addr_q  : '0;
        bus_write  = bus_drive ? write_q : 1'b0;
        bus_wdata  = (bus_drive && write_q) ? wdata_q : '0;
        resp_valid = resp_q;
        resp_err   = err_q;
        resp_rdata = rdata_q;
    end
endmodule

// File: rtl/hsk_bus_master_chk.sv
module hsk_bus_master_chk #(
    parameter int AW = 16,
    parameter int DW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          req_ready,
    input logic          resp_valid,
    input logic          bus_drive,
    input logic          bus_mrdy,
    input logic [AW-1:0] bus_addr,
    input logic          bus_write,
    input logic [DW-1:0] bus_wdata
);
    a_r2_addr_before_mrdy: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_mrdy) |-> $past(bus_drive));

    a_r9_bus_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_drive && $past(bus_drive)) |->
            ($stable(bus_addr) && $stable(bus_write) && $stable(bus_wdata)));

    a_r7_ready_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (!bus_drive && !bus_mrdy));

    a_r6_resp_single: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |=> !resp_valid);

    a_r6_resp_after_release: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |-> (!bus_mrdy && !bus_drive));
endmodule

bind hsk_bus_master hsk_bus_master_chk #(.AW(AW), .DW(DW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_ready  (req_ready),
    .resp_valid (resp_valid),
    .bus_drive  (bus_drive),
    .bus_mrdy   (bus_mrdy),
    .bus_addr   (bus_addr),
    .bus_write  (bus_write),
    .bus_wdata  (bus_wdata)
);

// File: tb/sim_hsk_bus_master.sv
module sim_hsk_bus_master;
    localparam int AW   = 8;
    localparam int DW   = 16;
    localparam int PRE  = 3;
    localparam int POST = 2;
    localparam int TMO  = 12;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic          req_ready, resp_valid, resp_err;
    logic [DW-1:0] resp_rdata;
    logic [AW-1:0] bus_addr;
    logic          bus_write, bus_drive, bus_mrdy;
    logic [DW-1:0] bus_wdata;
    logic          bus_srdy = 1'b0;
    logic [DW-1:0] bus_rdata = '0;

    always #10 clk = ~clk;

    hsk_bus_master #(.AW(AW), .DW(DW), .SKEW_PRE(PRE), .SKEW_POST(POST), .TMO_CYC(TMO)) u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
        .resp_valid(resp_valid), .resp_err(resp_err), .resp_rdata(resp_rdata),
        .bus_addr(bus_addr), .bus_write(bus_write), .bus_wdata(bus_wdata),
        .bus_drive(bus_drive), .bus_mrdy(bus_mrdy), .bus_srdy(bus_srdy),
        .bus_rdata(bus_rdata)
    );

    int n_chk = 0;
    int n_fail = 0;

    task automatic chk(input bit ok, input string msg, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", msg, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] init_val(input int i);
        return DW'(16'hA000 + i * 17);
    endfunction

    // Slave model
    logic [DW-1:0] smem [16];
    logic [DW-1:0] exp_mem [16];
    bit            s_mute = 1'b0;
    int            s_lat = 1;
    int            s_drop = 1;
    logic [AW-1:0] last_waddr = '0;
    logic [DW-1:0] last_wdata = '0;

    initial begin
        for (int i = 0; i < 16; i++) begin
            smem[i]    = init_val(i);
            exp_mem[i] = init_val(i);
        end
        forever begin
            @(negedge clk);
            if (rst_n && bus_mrdy && !s_mute) begin
                if (bus_write) begin
                    smem[bus_addr[3:0]] = bus_wdata;
                    last_waddr = bus_addr;
                    last_wdata = bus_wdata;
                end else begin
                    bus_rdata = smem[bus_addr[3:0]];
                end
                repeat (s_lat) @(negedge clk);
                #1 bus_srdy = 1'b1;
                do @(negedge clk); while (bus_mrdy);
                repeat (s_drop) @(negedge clk);
                #1 bus_srdy = 1'b0;
            end
        end
    end

    // Scoreboard
    typedef struct {
        bit            err;
        bit            wr;
        logic [AW-1:0] addr;
        logic [DW-1:0] data;
    } exp_t;
    exp_t sb[$];

    logic prev_mrdy = 1'b0;
    int   pre_cnt = 0;
    int   post_cnt = 0;
    int   wait_cnt = 0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (bus_drive && !bus_mrdy) pre_cnt++;
            if (bus_mrdy && !prev_mrdy) begin
                chk(pre_cnt == PRE, "R2 guard periods before strobe", pre_cnt, PRE);
                pre_cnt = 0;
            end
            if (bus_mrdy && bus_srdy)  post_cnt++;
            if (bus_mrdy && !bus_srdy) wait_cnt++;
            if (!bus_mrdy && prev_mrdy) begin
                if (post_cnt > 0)
                    chk(post_cnt == POST + 2, "R5 strobe periods after answer", post_cnt, POST + 2);
                else begin
                    chk(wait_cnt == TMO, "R8 strobe periods before timeout", wait_cnt, TMO);
                    chk(!bus_drive && bus_addr == '0, "R8 bus released", int'(bus_drive), 0);
                end
                post_cnt = 0;
                wait_cnt = 0;
            end
            if (bus_srdy)
                chk(!req_ready, "R7 ready while answer high", int'(req_ready), 0);
            if (resp_valid) begin
                chk(!bus_srdy && !bus_mrdy, "R6 response before handshake end",
                    int'({bus_srdy, bus_mrdy}), 0);
                if (sb.size() == 0) begin
                    chk(1'b0, "R7 unexpected response", 1, 0);
                end else begin
                    exp_t e;
                    e = sb.pop_front();
                    if (e.err) begin
                        chk(resp_err == 1'b1, "R8 timeout error flag", int'(resp_err), 1);
                    end else if (e.wr) begin
                        chk(resp_err == 1'b0, "R3 write error flag", int'(resp_err), 0);
                        chk(last_waddr == e.addr, "R3 write address at slave", int'(last_waddr), int'(e.addr));
                        chk(last_wdata == e.data, "R3 write data at slave", int'(last_wdata), int'(e.data));
                    end else begin
                        chk(resp_err == 1'b0, "R4 read error flag", int'(resp_err), 0);
                        chk(resp_rdata == e.data, "R4 read data", int'(resp_rdata), int'(e.data));
                    end
                end
            end
            prev_mrdy = bus_mrdy;
        end
    end

    task automatic issue(input bit wr, input logic [AW-1:0] a, input logic [DW-1:0] d, input bit inject);
        exp_t e;
        e.err  = s_mute;
        e.wr   = wr;
        e.addr = a;
        e.data = wr ? d : exp_mem[a[3:0]];
        if (wr && !s_mute) exp_mem[a[3:0]] = d;
        sb.push_back(e);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1;
        req_write = wr;
        req_addr  = a;
        req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0;
        if (inject) begin
            while (!bus_mrdy) @(negedge clk);
            req_valid = 1'b1;
            req_write = 1'b1;
            req_addr  = 8'd7;
            req_wdata = 16'hFFFF;
            repeat (3) @(negedge clk);
            req_valid = 1'b0;
        end
        while (sb.size() != 0) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(!bus_mrdy && !bus_drive, "R1 bus idle in reset", int'({bus_mrdy, bus_drive}), 0);
        chk(!resp_valid, "R1 no response in reset", int'(resp_valid), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready, "R1 ready after reset", int'(req_ready), 1);

        // R3 writes, R4 reads
        issue(1'b1, 8'd1, 16'h1234, 1'b0);
        issue(1'b1, 8'd2, 16'hBEEF, 1'b0);
        issue(1'b1, 8'd4, 16'h0F0F, 1'b0);
        issue(1'b0, 8'd1, '0, 1'b0);
        issue(1'b0, 8'd2, '0, 1'b0);
        issue(1'b0, 8'd4, '0, 1'b0);
        issue(1'b0, 8'd9, '0, 1'b0);

        // R5 R6 slow slave: late answer, late release
        s_lat = 5; s_drop = 4;
        issue(1'b1, 8'd3, 16'h5A5A, 1'b0);
        issue(1'b0, 8'd3, '0, 1'b0);
        // fast slave
        s_lat = 0; s_drop = 0;
        issue(1'b1, 8'd5, 16'hC3C3, 1'b0);
        issue(1'b0, 8'd5, '0, 1'b0);

        // R7 request while busy is ignored
        s_lat = 4; s_drop = 1;
        issue(1'b0, 8'd2, '0, 1'b1);
        issue(1'b0, 8'd7, '0, 1'b0);

        // R8 timeouts
        s_mute = 1'b1;
        issue(1'b0, 8'd3, '0, 1'b0);
        issue(1'b1, 8'd8, 16'h7777, 1'b0);
        s_mute = 1'b0; s_lat = 1;
        issue(1'b0, 8'd8, '0, 1'b0);
        issue(1'b0, 8'd3, '0, 1'b0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired, R6 handshake hung actual=1 expected=0");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule